// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It handles a small integer subset: five register-to-register operations (add, subtract, bitwise AND, bitwise OR and signed set-on-less-than), word load, word store, branch on equal and an unconditional jump. Every datapath element has its own hardware, so nothing is shared within a cycle. The PC has a dedicated +4 adder, the branch target has a second adder, and the main ALU is separate from both. The register file provides two asynchronous read ports and one synchronous write port.

Control is split into two levels. A main decoder looks at the 6-bit opcode and produces a 2-bit ALU class. A second decoder then turns that class, together with the 6-bit function field, into the ALU operation. The function field has an effect only when the class says "register-to-register". Instruction and data storage are small internal word-addressed arrays. A load port fills them while the core is held in reset.

Observation ports show the state changes the core makes each cycle: the current PC and instruction, the register write (enable, address and data) and the data-memory write (enable, byte address and data).

Top module: `sc_cpu_core`

## Requirements
- R1: For register-to-register instructions (opcode 000000) the write address comes from bits 15-11 of the instruction. For loads (opcode 100011) it comes from bits 20-16.
- R2: Loads and stores (opcode 101011) form the byte address by adding the register selected by bits 25-21 to the sign-extended bits 15-0. The word index is that address shifted right by 2. A store writes the register selected by bits 20-16.
- R3: The main decoder produces ALU class 00 (add) for loads and stores, 01 (subtract) for branch-on-equal and 10 for opcode 000000. Only class 10 lets the function field (bits 5-0) choose the operation, so the low immediate bits of other instructions have no effect on the ALU.
- R4: Under class 10, function codes 100000, 100010, 100100 and 100101 give add, subtract, AND and OR.
- R5: Function code 101010 writes 1 when the first operand is less than the second, both taken as signed two's complement, and writes 0 otherwise.
- R6: Branch-on-equal (opcode 000100) subtracts its two registers. When the result is zero, the next PC is PC+4 plus the sign-extended offset shifted left by 2; when it is not zero, the next PC is PC+4.
- R7: Jump (opcode 000010) sets the next PC to the top 4 bits of PC+4, followed by instruction bits 25-0, followed by two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it leaves its value unchanged.
- R9: Any other opcode asserts neither register write nor memory write and advances the PC by 4.
- R10: While reset is high, the PC is loaded with 0 on every clock edge.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Writes load_data into one of the storage arrays |
| load_to_dmem | input | 1 | 1 selects data storage, 0 selects instruction storage |
| load_addr | input | MEM_AW | Word index for the load port |
| load_data | input | 32 | Word written through the load port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at pc_o |
| reg_we_o | output | 1 | Register write enable from the main decoder |
| reg_waddr_o | output | 5 | Register write address |
| reg_wdata_o | output | 32 | Register write data |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_addr_o | output | 32 | Data-memory byte address (ALU result) |
| mem_wdata_o | output | 32 | Data-memory write data |

## Verification
The assertions check several rules on every cycle. After a reset edge the PC is zero, and it steps by 4 whenever the current instruction is neither a branch nor a jump. A taken branch or a jump lands on its computed target. Loads and stores always drive the ALU to add and branches always drive it to subtract. Reads of register 0 return zero, and an unknown opcode writes nothing. Other behaviour is visible only through the bench's program: the values each ALU operation produces, the signed comparison, the choice of destination field, an ignored write to register 0 (seen through a later store of that register) and the exact next-PC sequence of the whole program.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RAW    = $clog2(NREGS);

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic [5:0] opcode;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_t;

    typedef struct packed {
        logic       known;
        logic       reg_write;
        logic       dst_is_rd;
        logic       src_is_imm;
        logic       mem_write;
        logic       wb_from_mem;
        logic       branch;
        logic       jump;
        alu_class_e alu_class;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
        return {{(XLEN-16){imm[15]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] jump_addr(input logic [XLEN-1:0] pc_plus4,
                                                  input logic [25:0] target);
        return {pc_plus4[XLEN-1:28], target, 2'b00};
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_cpu_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{known: 1'b0, reg_write: 1'b0, dst_is_rd: 1'b0, src_is_imm: 1'b0,
                 mem_write: 1'b0, wb_from_mem: 1'b0, branch: 1'b0, jump: 1'b0,
                 alu_class: CLS_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.known     = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_class = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.known       = 1'b1;
                ctrl.reg_write   = 1'b1;
                ctrl.src_is_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.known      = 1'b1;
                ctrl.src_is_imm = 1'b1;
                ctrl.mem_write  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.known     = 1'b1;
                ctrl.branch    = 1'b1;
                ctrl.alu_class = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl.known = 1'b1;
                ctrl.jump  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_cpu_pkg::*;
(
    input  alu_class_e cls,
    input  logic [5:0] funct,
    output alu_op_e    op
);
    always_comb begin
        case (cls)
            CLS_SUB:   op = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
            default:   op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_cpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_cpu_pkg::*;
#(
    parameter int N   = NREGS,
    parameter int W   = XLEN,
    parameter int NRD = 2,
    localparam int AW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] cells [N];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            cells[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : cells[raddr[p]];
    end
endmodule

// File: rtl/sc_word_mem.sv
module sc_word_mem #(
    parameter int AW = 6,
    parameter int W  = 32,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
    import sc_cpu_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic              load_to_dmem,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [31:0]       load_data,
    output logic [31:0]       pc_o,
    output logic [31:0]       instr_o,
    output logic              reg_we_o,
    output logic [4:0]        reg_waddr_o,
    output logic [31:0]       reg_wdata_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = MEM_AW + IDX_LO - 1;

    logic [XLEN-1:0]     pc_q, pc_next, pc_plus4, br_target, imm_ext;
    logic [XLEN-1:0]     instr_word, alu_b, alu_y, dmem_rdata, wb_data;
    instr_t              instr;
    ctrl_t               ctrl;
    alu_op_e             alu_op;
    logic                alu_zero;
    logic [1:0][RAW-1:0] rf_raddr;
    logic [1:0][XLEN-1:0] rf_rdata;
    logic [RAW-1:0]      rf_waddr;
    logic                dmem_we;
    logic [MEM_AW-1:0]   dmem_waddr;
    logic [XLEN-1:0]     dmem_wdata;

    // program counter and next-PC selection
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_plus4  = pc_q + XLEN'(4);
    assign imm_ext   = sext16(instr_word[15:0]);
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};

    always_comb begin
        if (ctrl.jump)                   pc_next = jump_addr(pc_plus4, instr_word[25:0]);
        else if (ctrl.branch && alu_zero) pc_next = br_target;
        else                             pc_next = pc_plus4;
    end

    // instruction storage
    sc_word_mem #(.AW(MEM_AW), .W(XLEN)) u_imem (
        .clk   (clk),
        .we    (load_we && !load_to_dmem),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc_q[IDX_HI:IDX_LO]),
        .rdata (instr_word)
    );
    assign instr = instr_t'(instr_word);

    // two-level control
    sc_main_dec u_main_dec (
        .opcode (instr.opcode),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls   (ctrl.alu_class),
        .funct (instr.funct),
        .op    (alu_op)
    );

    // register file
    assign rf_raddr[0] = instr.rs;
    assign rf_raddr[1] = instr.rt;
    assign rf_waddr    = ctrl.dst_is_rd ? instr.rd : instr.rt;

    sc_regfile #(.N(NREGS), .W(XLEN), .NRD(2)) u_regfile (
        .clk   (clk),
        .we    (ctrl.reg_write && !rst),
        .waddr (rf_waddr),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // execute
    assign alu_b = ctrl.src_is_imm ? imm_ext : rf_rdata[1];

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rf_rdata[0]),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data storage; the load port wins while it is active
    assign dmem_we    = (load_we && load_to_dmem) || (ctrl.mem_write && !rst);
    assign dmem_waddr = (load_we && load_to_dmem) ? load_addr : alu_y[IDX_HI:IDX_LO];
    assign dmem_wdata = (load_we && load_to_dmem) ? load_data : rf_rdata[1];

    sc_word_mem #(.AW(MEM_AW), .W(XLEN)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_y[IDX_HI:IDX_LO]),
        .rdata (dmem_rdata)
    );

    assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    // observation
    assign pc_o        = pc_q;
    assign instr_o     = instr_word;
    assign reg_we_o    = ctrl.reg_write;
    assign reg_waddr_o = rf_waddr;
    assign reg_wdata_o = wb_data;
    assign mem_we_o    = ctrl.mem_write;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = rf_rdata[1];

    // assertions
    assert_pc_reset_R10: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    assert_pc_step_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.branch && !ctrl.jump) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    assert_branch_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && alu_zero) |=> (pc_q == $past(br_target)));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q[27:0] == {$past(instr_word[25:0]), 2'b00}));

    assert_mem_adds_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mem_write || ctrl.wb_from_mem) |-> (alu_op == ALU_ADD));

    assert_branch_subs_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl.branch |-> (alu_op == ALU_SUB));

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (rf_raddr[0] == '0) |-> (rf_rdata[0] == '0));

    assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.known |-> (!reg_we_o && !mem_we_o));
endmodule

// File: tb/tb_sc_cpu_core.sv
module tb_sc_cpu_core;
    localparam int MEM_AW  = 6;
    localparam int N_PROG  = 16;
    localparam int N_STEPS = 18;
    localparam logic [31:0] ILLEGAL = 32'hFC00_0000;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] word;
    } prog_t;

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] pc;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        mwe;
        logic [31:0] ma;
        logic [31:0] md;
    } exp_t;

    localparam prog_t PROG [N_PROG] = '{
        '{6'd0,  32'h8C01_0000},  // lw  r1, 0(r0)
        '{6'd1,  32'h8C02_0004},  // lw  r2, 4(r0)
        '{6'd2,  32'h0022_1820},  // add r3, r1, r2
        '{6'd3,  32'h0022_2022},  // sub r4, r1, r2
        '{6'd4,  32'h0022_2824},  // and r5, r1, r2
        '{6'd5,  32'h0022_3025},  // or  r6, r1, r2
        '{6'd6,  32'h0041_382A},  // slt r7, r2, r1
        '{6'd7,  32'h0022_402A},  // slt r8, r1, r2
        '{6'd8,  32'hAC03_0008},  // sw  r3, 8(r0)
        '{6'd9,  32'h0021_0020},  // add r0, r1, r1
        '{6'd10, 32'hAC00_000C},  // sw  r0, 12(r0)
        '{6'd11, 32'h1022_0005},  // beq r1, r2, +5 (not taken)
        '{6'd12, 32'h1021_0025},  // beq r1, r1, +0x25 (offset low bits look like OR)
        '{6'd50, 32'h8C0A_0008},  // lw  r10, 8(r0)
        '{6'd51, 32'h0800_0014},  // j   0x50
        '{6'd21, 32'h1000_FFFF}   // beq r0, r0, -1 (self loop)
    };

    localparam exp_t EXP [N_STEPS] = '{
        '{"R2 ", 32'h00, 1'b1, 5'd1,  32'd5,         1'b0, 32'd0,  32'd0},
        '{"R11", 32'h04, 1'b1, 5'd2,  32'hFFFF_FFFD, 1'b0, 32'd0,  32'd0},
        '{"R1 ", 32'h08, 1'b1, 5'd3,  32'd2,         1'b0, 32'd0,  32'd0},
        '{"R4 ", 32'h0C, 1'b1, 5'd4,  32'd8,         1'b0, 32'd0,  32'd0},
        '{"R4 ", 32'h10, 1'b1, 5'd5,  32'd5,         1'b0, 32'd0,  32'd0},
        '{"R4 ", 32'h14, 1'b1, 5'd6,  32'hFFFF_FFFD, 1'b0, 32'd0,  32'd0},
        '{"R5 ", 32'h18, 1'b1, 5'd7,  32'd1,         1'b0, 32'd0,  32'd0},
        '{"R5 ", 32'h1C, 1'b1, 5'd8,  32'd0,         1'b0, 32'd0,  32'd0},
        '{"R2 ", 32'h20, 1'b0, 5'd0,  32'd0,         1'b1, 32'd8,  32'd2},
        '{"R8 ", 32'h24, 1'b1, 5'd0,  32'd10,        1'b0, 32'd0,  32'd0},
        '{"R8 ", 32'h28, 1'b0, 5'd0,  32'd0,         1'b1, 32'd12, 32'd0},
        '{"R6 ", 32'h2C, 1'b0, 5'd0,  32'd0,         1'b0, 32'd0,  32'd0},
        '{"R3 ", 32'h30, 1'b0, 5'd0,  32'd0,         1'b0, 32'd0,  32'd0},
        '{"R6 ", 32'hC8, 1'b1, 5'd10, 32'd2,         1'b0, 32'd0,  32'd0},
        '{"R7 ", 32'hCC, 1'b0, 5'd0,  32'd0,         1'b0, 32'd0,  32'd0},
        '{"R7 ", 32'h50, 1'b0, 5'd0,  32'd0,         1'b0, 32'd0,  32'd0},
        '{"R9 ", 32'h54, 1'b0, 5'd0,  32'd0,         1'b0, 32'd0,  32'd0},
        '{"R6 ", 32'h54, 1'b0, 5'd0,  32'd0,         1'b0, 32'd0,  32'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_we = 1'b0;
    logic              load_to_dmem = 1'b0;
    logic [MEM_AW-1:0] load_addr = '0;
    logic [31:0]       load_data = '0;
    logic [31:0]       pc_o, instr_o, reg_wdata_o, mem_addr_o, mem_wdata_o;
    logic              reg_we_o, mem_we_o;
    logic [4:0]        reg_waddr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sc_cpu_core #(.MEM_AW(MEM_AW)) dut (
        .clk          (clk),
        .rst          (rst),
        .load_we      (load_we),
        .load_to_dmem (load_to_dmem),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .pc_o         (pc_o),
        .instr_o      (instr_o),
        .reg_we_o     (reg_we_o),
        .reg_waddr_o  (reg_waddr_o),
        .reg_wdata_o  (reg_wdata_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic load_word(input logic to_dmem, input int idx, input logic [31:0] d);
        @(negedge clk);
        load_we      = 1'b1;
        load_to_dmem = to_dmem;
        load_addr    = MEM_AW'(idx);
        load_data    = d;
        @(negedge clk);
        load_we      = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R10: PC is zero after a reset edge
        @(negedge clk);
        check("R10", "pc in reset", pc_o, 32'h0);

        for (int i = 0; i < (1 << MEM_AW); i++) load_word(1'b0, i, ILLEGAL);
        for (int i = 0; i < N_PROG; i++) load_word(1'b0, int'(PROG[i].idx), PROG[i].word);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'hFFFF_FFFD);

        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int s = 0; s < N_STEPS; s++) begin
            if (s != 0) begin
                @(negedge clk);
                #1;
            end
            check(string'(EXP[s].tag), "pc", pc_o, EXP[s].pc);
            check(string'(EXP[s].tag), "reg_we", 32'(reg_we_o), 32'(EXP[s].we));
            if (EXP[s].we) begin
                check(string'(EXP[s].tag), "reg_waddr", 32'(reg_waddr_o), 32'(EXP[s].wa));
                check(string'(EXP[s].tag), "reg_wdata", reg_wdata_o, EXP[s].wd);
            end
            check(string'(EXP[s].tag), "mem_we", 32'(mem_we_o), 32'(EXP[s].mwe));
            if (EXP[s].mwe) begin
                check(string'(EXP[s].tag), "mem_addr", mem_addr_o, EXP[s].ma);
                check(string'(EXP[s].tag), "mem_wdata", mem_wdata_o, EXP[s].md);
            end
        end

        // R10: reset in mid-run returns to address 0 and restarts the program
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10", "pc after mid-run reset", pc_o, 32'h0);
        rst = 1'b0;
        #1;
        check("R10", "first instr after restart", instr_o, 32'h8C01_0000);
        check("R2", "restart load data", reg_wdata_o, 32'd5);
        @(negedge clk);
        #1;
        check("R11", "pc after restart step", pc_o, 32'h4);

        finish_run();
    end
endmodule